// File: doc/BRIEF.md
# Flash Read Response Selector

This block forms the value a parallel NOR flash returns on a read, given the operating mode that a separate command sequencer has already decided. Depending on that mode the read returns the addressed array word, an autoselect identifier, a status byte whose toggle and polling bits track program and erase activity, or an entry of the common flash interface (CFI) query table. The array storage and the command decoding stay outside; the sequencer reports program and erase events, and the array supplies its read word.

The read data path is combinational from the mode and word address inputs. The status byte is the only state. A read strobe taken while an operation is in progress flips its toggle bit. Program and erase events rewrite the byte. The query table is a constant ROM, and its geometry fields (device size, block count, sector size) are computed at elaboration from the sector size and block count parameters.

Top module: `flash_rdresp`

## Requirements
- R1: Reset (rst_n low, asynchronous) sets the status byte to 0x00.
- R2: Mode codes are 0 = array, 1 = waiting for erase unlock cycles, 2 = autoselect, 3 = busy (program or erase in progress), 4 = query; in modes 0 and 1, and for any unused code (5 to 7), rd_data_o equals arr_data_i.
- R3: In autoselect mode the word offset is addr_i[7:0]; offset 0x00 returns identifier ID0, offset 0x01 returns ID1, and offset 0x02 returns 0 (no sector protected), each zero-extended.
- R4: In autoselect mode offsets 0x0E and 0x0F return ID2 and ID3, except that an identifier equal to 16'hFFFF returns arr_data_i instead; every other offset returns arr_data_i.
- R5: In busy mode rd_data_o is the status byte zero-extended, and a read strobe in busy mode with no event in the same cycle inverts status bit 6 on the next clock edge.
- R6: A program event sets the status byte on the next edge to bit 7 = inverse of prog_data_i[7] and bits 6..0 = 1; it takes precedence over every other status update in the same cycle.
- R7: An erase start event (below a program event in priority) clears the status byte to 0x00; an erase completion event (below both) inverts bit 7 only; both take precedence over the read toggle.
- R8: In query mode the table index is addr_i[7:0]; indices at or above CFI_DEPTH read 0; indices 0x10, 0x11, 0x12 read 0x51, 0x52, 0x59 ("QRY"), and 0x13, 0x14 read 0x02, 0x00.
- R9: Query index 0x27 reads the base-2 logarithm of SECTOR_BYTES*NUM_BLOCKS, 0x2C reads 0x01, 0x2D/0x2E read the low/high byte of NUM_BLOCKS-1, and 0x2F/0x30 read bits 15..8 and 23..16 of SECTOR_BYTES.
- R10: A read strobe outside busy mode leaves the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Current read mode from the command sequencer |
| addr_i | input | ADDR_W | Word address of the read |
| arr_data_i | input | DATA_W | Array read word for addr_i |
| rd_stb_i | input | 1 | One-cycle read strobe |
| prog_evt_i | input | 1 | Program event, one cycle |
| prog_data_i | input | DATA_W | Data being programmed |
| erase_start_i | input | 1 | Erase start event, one cycle |
| erase_done_i | input | 1 | Erase completion event, one cycle |
| rd_data_o | output | DATA_W | Read response |
| status_o | output | 8 | Status byte |

## Verification
Every cycle, the assertions check the status byte's next value against each event and its priority, that the byte holds when nothing touches it, and that array, busy and out-of-range query reads route the right source. The exact identifier values, the fallback for an all-ones identifier, the query table contents and the computed geometry fields are only shown by the bench's vector table. The bench's directed sequence shows status values across chained program, erase and toggle steps.

// File: rtl/fl_resp_pkg.sv
package fl_resp_pkg;

   typedef enum logic [2:0] {
      FM_ARRAY       = 3'd0,
      FM_UNLOCK_WAIT = 3'd1,
      FM_AUTOSEL     = 3'd2,
      FM_BUSY        = 3'd3,
      FM_QUERY       = 3'd4
   } fl_mode_e;

   localparam int unsigned OFFS_W = 8;
   localparam int unsigned ID_W   = 16;

   // Query table byte at index idx; geometry supplied by the caller.
   function automatic logic [7:0] query_byte(input int unsigned idx,
                                             input int unsigned lg_size,
                                             input int unsigned blk_m1,
                                             input int unsigned sec_bytes);
      logic [31:0] tmp;
      tmp = 32'h0;
      case (idx)
         'h10: tmp = 32'h51;
         'h11: tmp = 32'h52;
         'h12: tmp = 32'h59;
         'h13: tmp = 32'h02;
         'h1B: tmp = 32'h27;
         'h1C: tmp = 32'h36;
         'h1F: tmp = 32'h07;
         'h20: tmp = 32'h04;
         'h21: tmp = 32'h09;
         'h22: tmp = 32'h0C;
         'h23: tmp = 32'h01;
         'h24: tmp = 32'h04;
         'h25: tmp = 32'h0A;
         'h26: tmp = 32'h0D;
         'h27: tmp = lg_size;
         'h28: tmp = 32'h02;
         'h2A: tmp = 32'h05;
         'h2C: tmp = 32'h01;
         'h2D: tmp = blk_m1;
         'h2E: tmp = blk_m1 >> 8;
         'h2F: tmp = sec_bytes >> 8;
         'h30: tmp = sec_bytes >> 16;
         default: tmp = 32'h0;
      endcase
      return tmp[7:0];
   endfunction

endpackage

// File: rtl/fl_query_rom.sv
module fl_query_rom
   import fl_resp_pkg::*;
#(
   parameter int unsigned CFI_DEPTH    = 64,
   parameter int unsigned SECTOR_BYTES = 65536,
   parameter int unsigned NUM_BLOCKS   = 128
) (
   input  logic [OFFS_W-1:0] idx_i,
   output logic [7:0]        q_o
);
   localparam int unsigned ROM_N = 1 << OFFS_W;
   localparam longint unsigned TOTAL_BYTES =
      longint'(SECTOR_BYTES) * longint'(NUM_BLOCKS);
   localparam int unsigned LG_SIZE = $clog2(TOTAL_BYTES);
   localparam int unsigned BLK_M1  = NUM_BLOCKS - 1;

   initial begin
      assert (CFI_DEPTH >= 'h31 && CFI_DEPTH <= ROM_N)
         else $error("CFI_DEPTH must cover the geometry fields and fit the offset");
      assert ((TOTAL_BYTES & (TOTAL_BYTES - 1)) == 0)
         else $error("total size must be a power of two");
      assert (NUM_BLOCKS >= 1 && NUM_BLOCKS <= 65536)
         else $error("NUM_BLOCKS out of range");
   end

   logic [7:0] rom [ROM_N];

   for (genvar i = 0; i < ROM_N; i++) begin : g_rom
      if (i < CFI_DEPTH) begin : g_used
         assign rom[i] = query_byte(i, LG_SIZE, BLK_M1, SECTOR_BYTES);
      end else begin : g_beyond
         assign rom[i] = 8'h00;
      end
   end

   assign q_o = rom[idx_i];

endmodule

// File: rtl/fl_ident_sel.sv
module fl_ident_sel
   import fl_resp_pkg::*;
#(
   parameter logic [ID_W-1:0] ID0 = 16'h0001,
   parameter logic [ID_W-1:0] ID1 = 16'h0000,
   parameter logic [ID_W-1:0] ID2 = 16'hFFFF,
   parameter logic [ID_W-1:0] ID3 = 16'hFFFF
) (
   input  logic [OFFS_W-1:0] offs_i,
   output logic [ID_W-1:0]   id_o,
   output logic              use_arr_o
);
   localparam logic [ID_W-1:0] ALL_ONES = '1;

   always_comb begin
      id_o      = '0;
      use_arr_o = 1'b0;
      case (offs_i)
         8'h00: id_o = ID0;
         8'h01: id_o = ID1;
         8'h02: id_o = '0;
         8'h0E: begin
            id_o      = ID2;
            use_arr_o = (ID2 == ALL_ONES);
         end
         8'h0F: begin
            id_o      = ID3;
            use_arr_o = (ID3 == ALL_ONES);
         end
         default: use_arr_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/fl_status_reg.sv
module fl_status_reg (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_busy_i,
   input  logic       prog_i,
   input  logic       prog_d7_i,
   input  logic       erase_start_i,
   input  logic       erase_done_i,
   output logic [7:0] status_o
);
   localparam logic [7:0] POLL_BIT   = 8'h80;
   localparam logic [7:0] TOGGLE_BIT = 8'h40;

   logic [7:0] st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             st_q <= 8'h00;
      else if (prog_i)        st_q <= {~prog_d7_i, 7'h7F};
      else if (erase_start_i) st_q <= 8'h00;
      else if (erase_done_i)  st_q <= st_q ^ POLL_BIT;
      else if (rd_busy_i)     st_q <= st_q ^ TOGGLE_BIT;
   end

   assign status_o = st_q;

   logic any_evt;
   assign any_evt = prog_i | erase_start_i | erase_done_i;

   p_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
      prog_i |=> status_o == {~$past(prog_d7_i), 7'h7F});

   p_erase_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_start_i && !prog_i) |=> status_o == 8'h00);

   p_erase_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_done_i && !prog_i && !erase_start_i) |=> status_o == ($past(status_o) ^ 8'h80));

   p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_busy_i && !any_evt) |=> status_o == ($past(status_o) ^ 8'h40));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_busy_i && !any_evt) |=> $stable(status_o));

endmodule

// File: rtl/flash_rdresp.sv
module flash_rdresp
   import fl_resp_pkg::*;
#(
   parameter int unsigned     DATA_W       = 16,
   parameter int unsigned     ADDR_W       = 20,
   parameter int unsigned     CFI_DEPTH    = 64,
   parameter int unsigned     SECTOR_BYTES = 65536,
   parameter int unsigned     NUM_BLOCKS   = 128,
   parameter logic [ID_W-1:0] ID0          = 16'h0001,
   parameter logic [ID_W-1:0] ID1          = 16'h0000,
   parameter logic [ID_W-1:0] ID2          = 16'hFFFF,
   parameter logic [ID_W-1:0] ID3          = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] arr_data_i,
   input  logic              rd_stb_i,
   input  logic              prog_evt_i,
   input  logic [DATA_W-1:0] prog_data_i,
   input  logic              erase_start_i,
   input  logic              erase_done_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [7:0]        status_o
);
   initial begin
      assert (DATA_W == 8 || DATA_W == 16 || DATA_W == 32)
         else $error("DATA_W must be 8, 16 or 32");
      assert (ADDR_W >= OFFS_W)
         else $error("ADDR_W must hold the word offset");
   end

   fl_mode_e          mode;
   logic [OFFS_W-1:0] offs;
   logic [ID_W-1:0]   id_val;
   logic              id_use_arr;
   logic [7:0]        q_byte;
   logic [7:0]        status;
   logic [DATA_W-1:0] id_ext, q_ext, st_ext;

   assign mode = fl_mode_e'(mode_i);
   assign offs = addr_i[OFFS_W-1:0];

   fl_ident_sel #(.ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)) u_ident (
      .offs_i    (offs),
      .id_o      (id_val),
      .use_arr_o (id_use_arr)
   );

   fl_query_rom #(
      .CFI_DEPTH    (CFI_DEPTH),
      .SECTOR_BYTES (SECTOR_BYTES),
      .NUM_BLOCKS   (NUM_BLOCKS)
   ) u_query (
      .idx_i (offs),
      .q_o   (q_byte)
   );

   fl_status_reg u_status (
      .clk           (clk),
      .rst_n         (rst_n),
      .rd_busy_i     (rd_stb_i && (mode == FM_BUSY)),
      .prog_i        (prog_evt_i),
      .prog_d7_i     (prog_data_i[7]),
      .erase_start_i (erase_start_i),
      .erase_done_i  (erase_done_i),
      .status_o      (status)
   );

   // Width adaptation of the 8- and 16-bit sources onto the bus.
   if (DATA_W == 8) begin : g_narrow
      assign id_ext = id_val[7:0];
      assign q_ext  = q_byte;
      assign st_ext = status;
   end else begin : g_wide
      assign id_ext = {{(DATA_W-ID_W){1'b0}}, id_val};
      assign q_ext  = {{(DATA_W-8){1'b0}}, q_byte};
      assign st_ext = {{(DATA_W-8){1'b0}}, status};
   end

   always_comb begin
      case (mode)
         FM_AUTOSEL: rd_data_o = id_use_arr ? arr_data_i : id_ext;
         FM_BUSY:    rd_data_o = st_ext;
         FM_QUERY:   rd_data_o = q_ext;
         default:    rd_data_o = arr_data_i;
      endcase
   end

   assign status_o = status;

   p_array_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd0 || mode_i == 3'd1 || mode_i > 3'd4) |-> rd_data_o == arr_data_i);

   p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd3) |-> (rd_data_o[7:0] == status_o && (rd_data_o >> 8) == '0));

   p_query_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd4 && 32'(addr_i[OFFS_W-1:0]) >= CFI_DEPTH) |-> rd_data_o == '0);

endmodule

// File: tb/flash_rdresp_tb.sv
module flash_rdresp_tb;

   localparam int unsigned DW = 16;
   localparam int unsigned AW = 12;
   localparam int NV = 22;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    mode = 3'd0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] arr = '0;
   logic          rd_stb = 1'b0;
   logic          prog = 1'b0;
   logic [DW-1:0] pdata = '0;
   logic          es = 1'b0;
   logic          ed = 1'b0;
   logic [DW-1:0] rd_data;
   logic [7:0]    status;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   flash_rdresp #(
      .DATA_W(DW), .ADDR_W(AW), .CFI_DEPTH(64),
      .SECTOR_BYTES(4096), .NUM_BLOCKS(512),
      .ID0(16'h0001), .ID1(16'h227E), .ID2(16'h2210), .ID3(16'hFFFF)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .addr_i(addr),
      .arr_data_i(arr), .rd_stb_i(rd_stb), .prog_evt_i(prog),
      .prog_data_i(pdata), .erase_start_i(es), .erase_done_i(ed),
      .rd_data_o(rd_data), .status_o(status)
   );

   // {mode, addr, array word, expected, requirement number}
   localparam logic [50:0] VEC [NV] = '{
      {3'd0, 12'h123, 16'hBEEF, 16'hBEEF, 4'd2},  // R2 array
      {3'd1, 12'h555, 16'h1234, 16'h1234, 4'd2},  // R2 unlock wait
      {3'd7, 12'h000, 16'h4321, 16'h4321, 4'd2},  // R2 unused code
      {3'd2, 12'h000, 16'hAAAA, 16'h0001, 4'd3},  // R3 ID0
      {3'd2, 12'h001, 16'hAAAA, 16'h227E, 4'd3},  // R3 ID1
      {3'd2, 12'h002, 16'hAAAA, 16'h0000, 4'd3},  // R3 protection word
      {3'd2, 12'h100, 16'hCCCC, 16'h0001, 4'd3},  // R3 offset wraps on low byte
      {3'd2, 12'h00E, 16'hAAAA, 16'h2210, 4'd4},  // R4 ID2
      {3'd2, 12'h00F, 16'h5A5A, 16'h5A5A, 4'd4},  // R4 all-ones ID3 falls back
      {3'd2, 12'h003, 16'h7777, 16'h7777, 4'd4},  // R4 other offset
      {3'd4, 12'h010, 16'hFFFF, 16'h0051, 4'd8},  // R8 Q
      {3'd4, 12'h011, 16'hFFFF, 16'h0052, 4'd8},  // R8 R
      {3'd4, 12'h012, 16'hFFFF, 16'h0059, 4'd8},  // R8 Y
      {3'd4, 12'h013, 16'hFFFF, 16'h0002, 4'd8},  // R8 command set low
      {3'd4, 12'h014, 16'hFFFF, 16'h0000, 4'd8},  // R8 command set high
      {3'd4, 12'h0FF, 16'hFFFF, 16'h0000, 4'd8},  // R8 beyond depth
      {3'd4, 12'h027, 16'hFFFF, 16'h0015, 4'd9},  // R9 log2(2 MiB)
      {3'd4, 12'h02C, 16'hFFFF, 16'h0001, 4'd9},  // R9 region count
      {3'd4, 12'h02D, 16'hFFFF, 16'h00FF, 4'd9},  // R9 blocks-1 low
      {3'd4, 12'h02E, 16'hFFFF, 16'h0001, 4'd9},  // R9 blocks-1 high
      {3'd4, 12'h02F, 16'hFFFF, 16'h0010, 4'd9},  // R9 sector/256 low
      {3'd4, 12'h130, 16'hFFFF, 16'h0000, 4'd9}   // R9 sector/256 high
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic pulse(ref logic sig);
      @(negedge clk) sig = 1'b1;
      @(negedge clk) sig = 1'b0;
      #1;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      mode = 3'd3;
      repeat (3) @(negedge clk);
      #1 chk("R1 reset status", {24'h0, status}, 32'h00);
      @(negedge clk) rst_n = 1'b1;
      #1 chk("R1 busy read after reset", {16'h0, rd_data}, 32'h0000);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {mode, addr, arr} = VEC[i][50:20];
         #1 chk($sformatf("R%0d vector %0d", VEC[i][3:0], i),
                {16'h0, rd_data}, {16'h0, VEC[i][19:4]});
      end

      mode = 3'd3;
      pulse(rd_stb);
      chk("R5 toggle set", {16'h0, rd_data}, 32'h0040);
      pulse(rd_stb);
      chk("R5 toggle clear", {24'h0, status}, 32'h00);

      @(negedge clk) mode = 3'd0;
      pulse(rd_stb);
      chk("R10 no toggle in array mode", {24'h0, status}, 32'h00);

      pdata = 16'h0080;
      pulse(prog);
      chk("R6 program d7=1", {24'h0, status}, 32'h7F);

      @(negedge clk) begin mode = 3'd3; pdata = 16'h0000; rd_stb = 1'b1; prog = 1'b1; end
      @(negedge clk) begin rd_stb = 1'b0; prog = 1'b0; end
      #1 chk("R6 program beats toggle", {16'h0, rd_data}, 32'h00FF);

      pulse(es);
      chk("R7 erase start clears", {24'h0, status}, 32'h00);
      pulse(ed);
      chk("R7 erase done flips bit 7", {24'h0, status}, 32'h80);
      pulse(rd_stb);
      chk("R5 toggle during erase", {24'h0, status}, 32'hC0);

      @(negedge clk) begin es = 1'b1; ed = 1'b1; end
      @(negedge clk) begin es = 1'b0; ed = 1'b0; end
      #1 chk("R7 start beats done", {24'h0, status}, 32'h00);

      @(negedge clk) begin ed = 1'b1; rd_stb = 1'b1; end
      @(negedge clk) begin ed = 1'b0; rd_stb = 1'b0; end
      #1 chk("R7 done beats toggle", {24'h0, status}, 32'h80);

      @(negedge clk) rst_n = 1'b0;
      #1 chk("R1 reset mid-run", {24'h0, status}, 32'h00);
      @(negedge clk) rst_n = 1'b1;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule